// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block sits beside a real-time clock's time-of-day counters and decides, once per second, whether the programmed alarm time has been reached. On each update strobe it compares the current hour, minute and second bytes against three alarm bytes and latches two sticky status flags. The update flag records that an update happened. The alarm flag records that the time matched. An interrupt flag is raised when a flag that was clear becomes set and its enable is on. Software clears all flags together with a single acknowledge pulse, which is the equivalent of reading the status register.

Any alarm byte may be made a wildcard, so that it matches every value. This gives alarms once a day, once an hour, once a minute or once a second. Both the current and the alarm bytes are read as BCD or as binary, and hours as 24-hour or as 12-hour with a PM marker, as the two mode inputs select. The block keeps no time of its own. The counters that advance the time lie outside it.

Top module: `rtc_alarm_matcher`

## Requirements
- R1: After reset, `uf`, `af` and `irq_flag` are all 0.
- R2: With `bin_mode`=0, each byte is read as BCD, with value = bits[6:4]*10 + bits[3:0]. A field matches when the decoded values are equal. For example, 0x45 means 45.
- R3: With `bin_mode`=1, each byte is read as a plain binary value bits[6:0]. For example, 0x2D means 45.
- R4: An alarm byte whose bits[7:6] are 2'b11 is a wildcard and matches any current value of its field. The alarm fires when all three fields match, so an alarm with every field wildcarded fires on every strobe.
- R5: Each `upd_stb` pulse sets `uf` in the cycle after the pulse, provided `div_hold`=0. `uf` stays set until acknowledged.
- R6: `af` is set in the cycle after a strobe on which all three fields match. It is never set without a strobe, and it stays set until acknowledged.
- R7: `irq_flag` is set only by a strobe that newly sets `uf` while `uf_en`=1, or that newly sets `af` while `af_en`=1. A flag that was already set raises no interrupt. `irq_flag` stays set until acknowledged.
- R8: With `h24_mode`=0, hour bit 7 marks PM and bits[6:0] hold 1 to 12. 12 without PM means hour 0, 12 with PM means hour 12, and any other value with PM means value+12. Current and alarm hours are both converted to this 0 to 23 form before they are compared. With `h24_mode`=1, bits[6:0] hold the hour directly.
- R9: While `div_hold`=1, a strobe changes no flag.
- R10: `flag_ack` clears `uf`, `af` and `irq_flag` in the next cycle. When a strobe arrives in the same cycle as the acknowledge, the strobe is judged against the cleared flags, so its events count as new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | One-cycle once-per-second update strobe |
| div_hold | input | 1 | Dividers held in reset; suppresses update events |
| bin_mode | input | 1 | 1: binary fields, 0: BCD fields |
| h24_mode | input | 1 | 1: 24-hour hours, 0: 12-hour with PM in bit 7 |
| uf_en | input | 1 | Interrupt enable for the update flag |
| af_en | input | 1 | Interrupt enable for the alarm flag |
| flag_ack | input | 1 | Clears all flags (status read) |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hour | input | 8 | Alarm hours byte |
| uf | output | 1 | Update flag |
| af | output | 1 | Alarm flag |
| irq_flag | output | 1 | Interrupt request flag |

## Verification
The hardest case to reach is a strobe that arrives in the same cycle as an acknowledge while the flags are already set. The interrupt then depends on the flags being judged after they are cleared, not before. A second hard case is 12-hour hours whose raw bytes are unequal but whose converted values compare in a particular way, most of all the 12 AM and 12 PM codes. Directed sequences set up both cases on purpose: an acknowledge on the same edge as a strobe, with interrupts enabled, and the 12 AM and 12 PM codes paired against each other. A long stretch of mixed random stimulus then biases the alarm bytes towards copies of the current bytes and towards wildcards. This makes matches frequent in every mode, and a behavioural model checks each cycle.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
    localparam int BYTE_W = 8;
    localparam int VAL_W  = 7;
    localparam int N_FLD  = 3;
    localparam int HOUR_IDX = 2;

    typedef struct packed {
        logic uf;
        logic af;
        logic irqf;
    } flag_t;

    typedef struct packed {
        flag_t flags;
    } flag_state_t;
endpackage

// File: rtl/rtc_alm_field_dec.sv
module rtc_alm_field_dec
    import rtc_alm_pkg::*;
#(
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [BYTE_W-1:0] raw_i,
    input  logic              bin_mode_i,
    input  logic              h24_mode_i,
    output logic [VAL_W-1:0]  val_o,
    output logic              wild_o
);
    logic [VAL_W-1:0] base_val;

    always_comb begin
        if (bin_mode_i)
            base_val = raw_i[VAL_W-1:0];
        else
            base_val = VAL_W'(raw_i[6:4]) * VAL_W'(10) + VAL_W'(raw_i[3:0]);
    end

    assign wild_o = (raw_i[7:6] == 2'b11);

    generate
        if (IS_HOUR) begin : g_hour
            logic pm;
            assign pm = !h24_mode_i && raw_i[7];
            always_comb begin
                if (h24_mode_i)
                    val_o = base_val;
                else if (base_val == VAL_W'(12))
                    val_o = pm ? VAL_W'(12) : VAL_W'(0);
                else if (pm)
                    val_o = base_val + VAL_W'(12);
                else
                    val_o = base_val;
            end
        end else begin : g_plain
            assign val_o = base_val;
        end
    endgenerate
endmodule

// File: rtl/rtc_alm_cmp.sv
module rtc_alm_cmp
    import rtc_alm_pkg::*;
(
    input  logic [N_FLD-1:0][BYTE_W-1:0] cur_i,
    input  logic [N_FLD-1:0][BYTE_W-1:0] alm_i,
    input  logic                         bin_mode_i,
    input  logic                         h24_mode_i,
    output logic                         match_o
);
    logic [N_FLD-1:0] fld_hit;

    generate
        for (genvar i = 0; i < N_FLD; i++) begin : g_fld
            logic [VAL_W-1:0] cur_v, alm_v;
            logic             cur_w, alm_w;
            rtc_alm_field_dec #(.IS_HOUR(i == HOUR_IDX)) u_cur (
                .raw_i(cur_i[i]), .bin_mode_i(bin_mode_i), .h24_mode_i(h24_mode_i),
                .val_o(cur_v), .wild_o(cur_w)
            );
            rtc_alm_field_dec #(.IS_HOUR(i == HOUR_IDX)) u_alm (
                .raw_i(alm_i[i]), .bin_mode_i(bin_mode_i), .h24_mode_i(h24_mode_i),
                .val_o(alm_v), .wild_o(alm_w)
            );
            logic unused_cur_w;
            assign unused_cur_w = cur_w;
            assign fld_hit[i] = alm_w || (cur_v == alm_v);
        end
    endgenerate

    assign match_o = &fld_hit;
endmodule

// File: rtl/rtc_alm_flags.sv
module rtc_alm_flags
    import rtc_alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_stb_i,
    input  logic div_hold_i,
    input  logic match_i,
    input  logic uf_en_i,
    input  logic af_en_i,
    input  logic ack_i,
    output flag_t flags_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        flag_t base;
        logic  new_uf, new_af;
        base   = ack_i ? '0 : st_q.flags;
        st_d   = '{flags: base};
        new_uf = 1'b0;
        new_af = 1'b0;
        if (upd_stb_i && !div_hold_i) begin
            new_uf = !base.uf;
            new_af = match_i && !base.af;
            st_d.flags.uf = 1'b1;
            if (match_i) st_d.flags.af = 1'b1;
            if ((new_uf && uf_en_i) || (new_af && af_en_i))
                st_d.flags.irqf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    // R5 R6 R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_stb_i && !ack_i) |=> $stable(st_q.flags));

    // R9
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_hold_i && !ack_i) |=> $stable(st_q.flags));

    // R10
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !upd_stb_i) |=> (st_q.flags == '0));

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flags.irqf) |-> ($past(upd_stb_i) && ($past(uf_en_i) || $past(af_en_i))));

    // R6
    af_needs_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flags.af |-> st_q.flags.uf);
endmodule

// File: rtl/rtc_alarm_matcher.sv
module rtc_alarm_matcher
    import rtc_alm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_stb,
    input  logic       div_hold,
    input  logic       bin_mode,
    input  logic       h24_mode,
    input  logic       uf_en,
    input  logic       af_en,
    input  logic       flag_ack,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    output logic       uf,
    output logic       af,
    output logic       irq_flag
);
    logic [N_FLD-1:0][BYTE_W-1:0] cur_bus, alm_bus;
    logic  match;
    flag_t flags;

    assign cur_bus = {cur_hour, cur_min, cur_sec};
    assign alm_bus = {alm_hour, alm_min, alm_sec};

    rtc_alm_cmp u_cmp (
        .cur_i(cur_bus), .alm_i(alm_bus),
        .bin_mode_i(bin_mode), .h24_mode_i(h24_mode),
        .match_o(match)
    );

    rtc_alm_flags u_flags (
        .clk(clk), .rst_n(rst_n), .upd_stb_i(upd_stb), .div_hold_i(div_hold),
        .match_i(match), .uf_en_i(uf_en), .af_en_i(af_en), .ack_i(flag_ack),
        .flags_o(flags)
    );

    assign uf       = flags.uf;
    assign af       = flags.af;
    assign irq_flag = flags.irqf;
endmodule

// File: tb/rtc_alarm_matcher_tb.sv
module rtc_alarm_matcher_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_stb = 0, div_hold = 0, bin_mode = 0, h24_mode = 1;
    logic uf_en = 0, af_en = 0, flag_ack = 0;
    logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0;
    logic [7:0] alm_sec = 0, alm_min = 0, alm_hour = 0;
    logic uf, af, irq_flag;

    int vectors = 0;
    int fails = 0;
    bit m_uf = 0, m_af = 0, m_irq = 0;

    always #2.5 clk = ~clk;

    rtc_alarm_matcher dut_i (.*);

    function automatic int decode(input logic [7:0] b, input bit bin, input bit is_hr, input bit h24);
        int v;
        bit pm;
        v = bin ? int'(b[6:0]) : int'(b[6:4]) * 10 + int'(b[3:0]);
        if (is_hr && !h24) begin
            pm = b[7];
            if (v == 12) v = pm ? 12 : 0;
            else if (pm) v = v + 12;
        end
        return v;
    endfunction

    function automatic bit fmatch(input logic [7:0] c, input logic [7:0] a, input bit is_hr);
        if (a[7:6] == 2'b11) return 1;
        return decode(c, bin_mode, is_hr, h24_mode) == decode(a, bin_mode, is_hr, h24_mode);
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_uf = 0; m_af = 0; m_irq = 0;
        end else begin
            bit b_uf, b_af, b_irq, hit;
            b_uf = flag_ack ? 0 : m_uf;
            b_af = flag_ack ? 0 : m_af;
            b_irq = flag_ack ? 0 : m_irq;
            if (upd_stb && !div_hold) begin
                hit = fmatch(cur_sec, alm_sec, 0) && fmatch(cur_min, alm_min, 0)
                      && fmatch(cur_hour, alm_hour, 1);
                if ((!b_uf && uf_en) || (hit && !b_af && af_en)) b_irq = 1;
                b_uf = 1;
                if (hit) b_af = 1;
            end
            m_uf = b_uf; m_af = b_af; m_irq = b_irq;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (uf !== m_uf) begin fails++; $display("FAIL R5 uf actual=%b expected=%b", uf, m_uf); end
            if (af !== m_af) begin fails++; $display("FAIL R6 af actual=%b expected=%b", af, m_af); end
            if (irq_flag !== m_irq) begin fails++; $display("FAIL R7 irq actual=%b expected=%b", irq_flag, m_irq); end
        end
    end

    task automatic chk(input string req, input bit e_uf, input bit e_af, input bit e_irq);
        vectors++;
        if ({uf, af, irq_flag} !== {e_uf, e_af, e_irq}) begin
            fails++;
            $display("FAIL %s uf/af/irq actual=%b%b%b expected=%b%b%b", req, uf, af, irq_flag, e_uf, e_af, e_irq);
        end
    endtask

    task automatic strobe();
        upd_stb = 1; @(negedge clk); upd_stb = 0;
    endtask

    task automatic ack();
        flag_ack = 1; @(negedge clk); flag_ack = 0;
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                            input logic [7:0] ah, input logic [7:0] am, input logic [7:0] as_);
        cur_hour = h; cur_min = m; cur_sec = s; alm_hour = ah; alm_min = am; alm_sec = as_;
    endtask

    initial begin
        #(5ns * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", 0, 0, 0);

        // R2 BCD match
        bin_mode = 0; h24_mode = 1;
        set_time(8'h13, 8'h27, 8'h45, 8'h13, 8'h27, 8'h45);
        strobe(); chk("R2", 1, 1, 0);
        ack(); chk("R10", 0, 0, 0);
        set_time(8'h13, 8'h27, 8'h45, 8'h13, 8'h27, 8'h46);
        strobe(); chk("R2", 1, 0, 0);
        ack();

        // R3 binary: 0x2D means 45
        bin_mode = 1;
        set_time(8'd13, 8'd27, 8'h2D, 8'd13, 8'd27, 8'd45);
        strobe(); chk("R3", 1, 1, 0);
        ack();

        // R4 full wildcard fires every strobe
        set_time(8'd5, 8'd6, 8'd7, 8'hC0, 8'hFF, 8'hC3);
        af_en = 1;
        strobe(); chk("R4", 1, 1, 1);
        ack();
        set_time(8'd9, 8'd59, 8'd1, 8'hC0, 8'hFF, 8'hC3);
        strobe(); chk("R4", 1, 1, 1);
        ack();

        // R7 already-set flag raises no irq
        af_en = 0; uf_en = 0;
        strobe(); chk("R7", 1, 1, 0);
        uf_en = 1; af_en = 1;
        strobe(); chk("R7", 1, 1, 0);

        // R10 ack with strobe in same cycle: events are new
        flag_ack = 1; upd_stb = 1; @(negedge clk); flag_ack = 0; upd_stb = 0;
        chk("R10", 1, 1, 1);
        ack(); uf_en = 0; af_en = 0;

        // R6/R11: match without strobe sets nothing
        repeat (3) @(negedge clk);
        chk("R6", 0, 0, 0);

        // R8 12-hour conversion, BCD
        bin_mode = 0; h24_mode = 0;
        set_time(8'h12, 8'h00, 8'h00, 8'h92, 8'h00, 8'h00); // 12AM vs 12PM
        strobe(); chk("R8", 1, 0, 0); ack();
        set_time(8'h92, 8'h00, 8'h00, 8'h92, 8'h00, 8'h00); // 12PM vs 12PM
        strobe(); chk("R8", 1, 1, 0); ack();
        set_time(8'h81, 8'h30, 8'h00, 8'h81, 8'h30, 8'h00); // 1PM
        strobe(); chk("R8", 1, 1, 0); ack();
        set_time(8'h81, 8'h30, 8'h00, 8'h01, 8'h30, 8'h00); // 1PM vs 1AM
        strobe(); chk("R8", 1, 0, 0); ack();

        // R9 divider hold
        div_hold = 1; uf_en = 1; af_en = 1;
        set_time(8'h01, 8'h00, 8'h00, 8'hC0, 8'hC0, 8'hC0);
        strobe(); chk("R9", 0, 0, 0);
        div_hold = 0;
        strobe(); chk("R5", 1, 1, 1);
        ack();

        // random mixed stimulus
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] c [3];
            logic [7:0] a [3];
            for (int k = 0; k < 3; k++) begin
                c[k] = 8'($urandom);
                case ($urandom % 4)
                    0, 1: a[k] = c[k];
                    2: a[k] = 8'hC0 | 8'($urandom);
                    default: a[k] = 8'($urandom);
                endcase
            end
            set_time(c[2], c[1], c[0], a[2], a[1], a[0]);
            bin_mode = 1'($urandom); h24_mode = 1'($urandom);
            uf_en = 1'($urandom); af_en = 1'($urandom);
            div_hold = (($urandom % 8) == 0);
            upd_stb = 1'($urandom);
            flag_ack = (($urandom % 3) == 0);
            @(negedge clk);
        end
        upd_stb = 0; flag_ack = 0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule